// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Expander

This block lives inside a local interrupt controller. When software writes the low half of the interrupt command word, the block decodes the destination shorthand, the destination mode, the delivery mode and the 8-bit destination field. It turns them into a bitmask of remote agents that the interrupt fabric must reach. If the command also addresses the sending unit, the block raises a one-cycle local request that carries the vector, delivery mode and trigger. The sender is never placed in the remote mask.

The block keeps a saturating count of interprocessor interrupts that are still outstanding. Each write adds the number of remote targets to the count. Each completion pulse from the fabric removes one. The command word is held in a register, and reads return that stored copy. The delivery-status bit of the stored copy is owned by hardware, so a software write never overwrites a status update. Any lowest-priority request with the field-addressed shorthand is rejected with an error pulse and produces no targets.

Command word layout: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11 (1 = logical), delivery status in bit 12, trigger in bit 15, shorthand in bits 19:18.

Top module: `ipi_dest_expander`

## Requirements
- R1: With shorthand 0 and destination mode 1 (logical), destination bit i selects agent i for every i below `agent_cnt`. Bits at or above `agent_cnt` have no effect.
- R2: With shorthand 0, destination mode 0 (physical) and destination 0xFF, every agent below `agent_cnt` is selected.
- R3: With shorthand 0, physical mode and any other destination value: if the value equals `own_id`, the local request is raised. Otherwise, if the value is below `agent_cnt`, only that agent is selected. Otherwise nothing is selected.
- R4: Bit `own_id` of `tgt_mask` is never set. When the sender's own slot is selected, `local_req` pulses, and `local_vector`, `local_mode` and `local_trig` carry bits 7:0, 10:8 and 15 of the command.
- R5: Shorthand 1 selects only the sender, provided `own_id` is below `agent_cnt`.
- R6: Shorthand 2 selects every agent below `agent_cnt`, including the sender.
- R7: Shorthand 3 selects every agent below `agent_cnt` except the sender.
- R8: Shorthand 0 with delivery mode 3'b001 (lowest priority) pulses `cmd_err`, leaves `tgt_mask` at zero and leaves `local_req` low. That delivery mode causes no error with the other shorthands.
- R9: The results of a write appear on the clock edge that samples `cmd_wr`. They stay for exactly one cycle, then `tgt_mask`, `local_req` and `cmd_err` return to zero.
- R10: On each write, `pending` grows by the number of bits set in the resulting `tgt_mask`. It falls by one on each `ipi_done` cycle. It saturates at its all-ones value and never drops below zero.
- R11: `cmd_rdata` returns the last written command word, except that bit 12 is set while `pending` is nonzero and clear otherwise, whatever value software wrote to that bit.
- R12: After a synchronous active-low reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word low half |
| cmd_wdata | input | 32 | Command word being written |
| dest_field | input | 8 | Destination field that goes with the command |
| own_id | input | ID_W (3) | ID of this unit |
| agent_cnt | input | AC_W (4) | Number of agents present |
| ipi_done | input | 1 | One outstanding interrupt has completed |
| tgt_mask | output | MAX_AGENTS (8) | Remote agents to be reached, one-cycle pulse |
| local_req | output | 1 | Self-delivery request, one-cycle pulse |
| local_vector | output | 8 | Vector for the self-delivery |
| local_mode | output | 3 | Delivery mode for the self-delivery |
| local_trig | output | 1 | Trigger for the self-delivery |
| cmd_err | output | 1 | Unsupported command rejected |
| pending | output | CNT_W (8) | Outstanding interprocessor interrupt count |
| cmd_rdata | output | 32 | Stored command word with live delivery status |

## Verification
The vector table walks each shorthand under varied sender IDs and agent counts. Logical-mode patterns set destination bits above the agent count and on the sender's own position, which separates range masking from self-stripping. Physical-mode patterns use broadcast, a match with the sender, a plain unicast and an out-of-range unicast, so each branch of the unicast rule gives a different answer. Directed runs then push the counter into saturation, combine a completion with a write, and write the status bit from software to show that the stored copy ignores it.

// File: rtl/ipi_exp_pkg.sv
// Package: shared encodings and field positions for the interprocessor
// interrupt destination expander. Assumes a 32-bit command word low half.
package ipi_exp_pkg;

    // Destination shorthand codes (bits 19:18 of the command word).
    typedef enum logic [1:0] {
        SH_FIELD    = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL_INCL = 2'd2,
        SH_ALL_EXCL = 2'd3
    } shorthand_e;

    // Delivery mode value that is rejected with the field shorthand.
    localparam logic [2:0] DLV_LOWEST = 3'b001;

    // Field positions inside the command word.
    localparam int VEC_LSB    = 0;
    localparam int DLV_LSB    = 8;
    localparam int DMODE_BIT  = 11;
    localparam int STATUS_BIT = 12;
    localparam int TRIG_BIT   = 15;
    localparam int SH_LSB     = 18;

    // Decoded view of a command word.
    typedef struct packed {
        shorthand_e  sh;
        logic        trig;
        logic        logical;
        logic [2:0]  dlv;
        logic [7:0]  vector;
    } cmd_fields_t;

    // Split a command word into its fields.
    function automatic cmd_fields_t unpack_cmd(input logic [31:0] w);
        cmd_fields_t f;
        f.sh      = shorthand_e'(w[SH_LSB +: 2]);
        f.trig    = w[TRIG_BIT];
        f.logical = w[DMODE_BIT];
        f.dlv     = w[DLV_LSB +: 3];
        f.vector  = w[VEC_LSB +: 8];
        return f;
    endfunction

endpackage

// File: rtl/ipi_target_decode.sv
// Module: ipi_target_decode
// Combinational decode of one command into a remote target mask, a
// self-delivery hit and an error flag. Assumes MAX_AGENTS <= 8, so every
// agent has a bit in the 8-bit destination field. The sender is always
// removed from the remote mask and reported through self_hit instead.
module ipi_target_decode
    import ipi_exp_pkg::*;
#(
    parameter int MAX_AGENTS = 8,
    localparam int ID_W = $clog2(MAX_AGENTS),
    localparam int AC_W = $clog2(MAX_AGENTS + 1)
) (
    input  shorthand_e             sh,
    input  logic                   logical,
    input  logic [2:0]             dlv,
    input  logic [7:0]             dest,
    input  logic [ID_W-1:0]        own_id,
    input  logic [AC_W-1:0]        agent_cnt,
    output logic [MAX_AGENTS-1:0]  remote,
    output logic                   self_hit,
    output logic                   err
);

    logic [MAX_AGENTS-1:0] present;   // agent index below agent_cnt
    logic [MAX_AGENTS-1:0] self_oh;   // one-hot of own_id
    logic [MAX_AGENTS-1:0] log_sel;   // logical-mode selection
    logic [MAX_AGENTS-1:0] phys_sel;  // physical-mode selection
    logic [MAX_AGENTS-1:0] sel;       // final selection including self
    logic                  bcast;

    assign bcast = (dest == 8'hFF);

    // Per-agent qualifiers, one slice per agent.
    for (genvar i = 0; i < MAX_AGENTS; i++) begin : g_agent
        localparam logic [AC_W-1:0] IDX_AC = AC_W'(i);
        localparam logic [ID_W-1:0] IDX_ID = ID_W'(i);
        localparam logic [7:0]      IDX_D  = 8'(i);
        assign present[i]  = (IDX_AC < agent_cnt);
        assign self_oh[i]  = (own_id == IDX_ID);
        assign log_sel[i]  = present[i] & dest[i];
        assign phys_sel[i] = present[i] & (bcast | (dest == IDX_D));
    end

    // Select the candidate set from the shorthand and flag unsupported use.
    always_comb begin
        err = 1'b0;
        unique case (sh)
            SH_FIELD: begin
                sel = logical ? log_sel : phys_sel;
                if (dlv == DLV_LOWEST) begin
                    err = 1'b1;
                    sel = '0;
                end
            end
            SH_SELF:     sel = present & self_oh;
            SH_ALL_INCL: sel = present;
            SH_ALL_EXCL: sel = present & ~self_oh;
            default:     sel = '0;
        endcase
    end

    // Strip the sender out of the remote set and report it separately.
    always_comb begin
        remote   = sel & ~self_oh;
        self_hit = |(sel & self_oh);
    end

endmodule

// File: rtl/ipi_popcount.sv
// Module: ipi_popcount
// Counts the set bits of a target mask. Purely combinational.
module ipi_popcount #(
    parameter int W = 8,
    localparam int OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     bits_in,
    output logic [OUT_W-1:0] ones
);

    // Sum the bits one at a time; the tool builds an adder tree.
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + OUT_W'(bits_in[i]);
        end
    end

endmodule

// File: rtl/ipi_pending_ctr.sv
// Module: ipi_pending_ctr
// Saturating counter of outstanding interprocessor interrupts. Adds a
// target count and subtracts one completion per cycle. Holds at all-ones
// and at zero. The next value is exported for status tracking.
module ipi_pending_ctr #(
    parameter int CNT_W = 8,
    parameter int ADD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADD_W-1:0]  add,
    input  logic              dec,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_nxt
);

    localparam logic [CNT_W:0] SAT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] wide;

    // Compute the next count with clamping at both ends.
    always_comb begin
        wide = {1'b0, count} + (CNT_W + 1)'(add);
        if (dec && (wide != '0)) begin
            wide = wide - 1'b1;
        end
        if (wide > SAT_MAX) begin
            count_nxt = {CNT_W{1'b1}};
        end else begin
            count_nxt = wide[CNT_W-1:0];
        end
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/ipi_dest_expander.sv
// Module: ipi_dest_expander (top)
// Expands a write to the interrupt command low half into a one-cycle remote
// target mask and a one-cycle self-delivery request. Keeps an outstanding
// count and a stored copy of the command. Bit 12 of that copy is owned by
// hardware and tracks a nonzero count. Assumes own_id is stable while
// cmd_wr is high.
module ipi_dest_expander
    import ipi_exp_pkg::*;
#(
    parameter int MAX_AGENTS = 8,
    parameter int CNT_W      = 8,
    localparam int ID_W = $clog2(MAX_AGENTS),
    localparam int AC_W = $clog2(MAX_AGENTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_wr,
    input  logic [31:0]            cmd_wdata,
    input  logic [7:0]             dest_field,
    input  logic [ID_W-1:0]        own_id,
    input  logic [AC_W-1:0]        agent_cnt,
    input  logic                   ipi_done,
    output logic [MAX_AGENTS-1:0]  tgt_mask,
    output logic                   local_req,
    output logic [7:0]             local_vector,
    output logic [2:0]             local_mode,
    output logic                   local_trig,
    output logic                   cmd_err,
    output logic [CNT_W-1:0]       pending,
    output logic [31:0]            cmd_rdata
);

    cmd_fields_t           f;
    logic [MAX_AGENTS-1:0] remote;
    logic                  self_hit;
    logic                  dec_err;
    logic [AC_W-1:0]       n_remote;
    logic [AC_W-1:0]       add_cnt;
    logic [CNT_W-1:0]      pend_nxt;
    logic [31:0]           cmd_q;
    logic                  sw_status_unused;

    assign f = unpack_cmd(cmd_wdata);
    assign sw_status_unused = cmd_wdata[STATUS_BIT];

    ipi_target_decode #(
        .MAX_AGENTS(MAX_AGENTS)
    ) u_decode (
        .sh        (f.sh),
        .logical   (f.logical),
        .dlv       (f.dlv),
        .dest      (dest_field),
        .own_id    (own_id),
        .agent_cnt (agent_cnt),
        .remote    (remote),
        .self_hit  (self_hit),
        .err       (dec_err)
    );

    ipi_popcount #(
        .W(MAX_AGENTS)
    ) u_popcount (
        .bits_in (remote),
        .ones    (n_remote)
    );

    // Only a write contributes new outstanding interrupts.
    assign add_cnt = cmd_wr ? n_remote : '0;

    ipi_pending_ctr #(
        .CNT_W(CNT_W),
        .ADD_W(AC_W)
    ) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .add       (add_cnt),
        .dec       (ipi_done),
        .count     (pending),
        .count_nxt (pend_nxt)
    );

    // Register the one-cycle dispatch results of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_mask  <= '0;
            local_req <= 1'b0;
            cmd_err   <= 1'b0;
        end else if (cmd_wr) begin
            tgt_mask  <= remote;
            local_req <= self_hit;
            cmd_err   <= dec_err;
        end else begin
            tgt_mask  <= '0;
            local_req <= 1'b0;
            cmd_err   <= 1'b0;
        end
    end

    // Capture the payload that goes with a self-delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_vector <= '0;
            local_mode   <= '0;
            local_trig   <= 1'b0;
        end else if (cmd_wr && self_hit) begin
            local_vector <= f.vector;
            local_mode   <= f.dlv;
            local_trig   <= f.trig;
        end
    end

    // Store the command before dispatch; status bit follows the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            if (cmd_wr) begin
                cmd_q <= cmd_wdata;
            end
            cmd_q[STATUS_BIT] <= (pend_nxt != '0);
        end
    end

    assign cmd_rdata = cmd_q;

endmodule

// File: rtl/ipi_dest_expander_chk.sv
// Module: ipi_dest_expander_chk
// Assertion checker bound into ipi_dest_expander. It tracks last-cycle
// copies of inputs and state in its own registers and relates them to the
// outputs.
module ipi_dest_expander_chk #(
    parameter int MAX_AGENTS = 8,
    parameter int CNT_W      = 8,
    localparam int ID_W = $clog2(MAX_AGENTS),
    localparam int AC_W = $clog2(MAX_AGENTS + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_wr,
    input logic [ID_W-1:0]       own_id,
    input logic [AC_W-1:0]       agent_cnt,
    input logic                  ipi_done,
    input logic [MAX_AGENTS-1:0] tgt_mask,
    input logic                  local_req,
    input logic                  cmd_err,
    input logic [CNT_W-1:0]      pending
);

    localparam int PEND_MAX = (1 << CNT_W) - 1;

    logic                  prev_wr;
    logic                  prev_done;
    logic [ID_W-1:0]       prev_own;
    logic [AC_W-1:0]       prev_cnt;
    logic [CNT_W-1:0]      prev_pend;
    logic [MAX_AGENTS-1:0] prev_self_oh;
    logic [MAX_AGENTS-1:0] prev_present;
    int                    grow_sum;

    // Keep one-cycle-old copies of the inputs and state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_wr   <= 1'b0;
            prev_done <= 1'b0;
            prev_own  <= '0;
            prev_cnt  <= '0;
            prev_pend <= '0;
        end else begin
            prev_wr   <= cmd_wr;
            prev_done <= ipi_done;
            prev_own  <= own_id;
            prev_cnt  <= agent_cnt;
            prev_pend <= pending;
        end
    end

    // Derive the sender and population masks of the previous cycle.
    always_comb begin
        for (int i = 0; i < MAX_AGENTS; i++) begin
            prev_self_oh[i] = (int'(prev_own) == i);
            prev_present[i] = (i < int'(prev_cnt));
        end
        grow_sum = int'(prev_pend) + $countones(tgt_mask);
    end

    // R9: a nonzero mask only follows a write.
    a_r9_mask_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_mask != '0) |-> prev_wr);

    // R9: a local request only follows a write.
    a_r9_local_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        local_req |-> prev_wr);

    // R8: a rejected command dispatches nothing.
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ((tgt_mask == '0) && !local_req));

    // R4: the sender never appears in the remote set.
    a_r4_no_self: assert property (@(posedge clk) disable iff (!rst_n)
        prev_wr |-> ((tgt_mask & prev_self_oh) == '0));

    // R1: no agent at or above the agent count is targeted.
    a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        prev_wr |-> ((tgt_mask & ~prev_present) == '0));

    // R10: without a completion the count grows by the remote target count.
    a_r10_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_done && (grow_sum <= PEND_MAX)) |-> (int'(pending) == grow_sum));

    // R10: without a completion the count never falls.
    a_r10_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !prev_done |-> (pending >= prev_pend));

endmodule

bind ipi_dest_expander ipi_dest_expander_chk #(
    .MAX_AGENTS(MAX_AGENTS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .own_id    (own_id),
    .agent_cnt (agent_cnt),
    .ipi_done  (ipi_done),
    .tgt_mask  (tgt_mask),
    .local_req (local_req),
    .cmd_err   (cmd_err),
    .pending   (pending)
);

// File: tb/test_ipi_dest_expander.sv
module test_ipi_dest_expander;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_wr;
    logic [31:0] cmd_wdata;
    logic [7:0]  dest_field;
    logic [2:0]  own_id;
    logic [3:0]  agent_cnt;
    logic        ipi_done;
    logic [7:0]  tgt_mask;
    logic        local_req;
    logic [7:0]  local_vector;
    logic [2:0]  local_mode;
    logic        local_trig;
    logic        cmd_err;
    logic [7:0]  pending;
    logic [31:0] cmd_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_pend = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipi_dest_expander i_ipi_dest_expander (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_wdata    (cmd_wdata),
        .dest_field   (dest_field),
        .own_id       (own_id),
        .agent_cnt    (agent_cnt),
        .ipi_done     (ipi_done),
        .tgt_mask     (tgt_mask),
        .local_req    (local_req),
        .local_vector (local_vector),
        .local_mode   (local_mode),
        .local_trig   (local_trig),
        .cmd_err      (cmd_err),
        .pending      (pending),
        .cmd_rdata    (cmd_rdata)
    );

    // Table entry: sh, logical, dlv, dest, own, cnt | exp mask, exp local, exp err
    localparam logic [30:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 3'd0, 8'hA5, 3'd0, 4'd8, 8'hA4, 1'b1, 1'b0}, // R1 R4 self bit set
        {2'd0, 1'b1, 3'd0, 8'hF0, 3'd2, 4'd6, 8'h30, 1'b0, 1'b0}, // R1 high bits dropped
        {2'd0, 1'b1, 3'd0, 8'hFF, 3'd1, 4'd3, 8'h05, 1'b1, 1'b0}, // R1 all bits, 3 agents
        {2'd0, 1'b0, 3'd0, 8'hFF, 3'd3, 4'd8, 8'hF7, 1'b1, 1'b0}, // R2 broadcast
        {2'd0, 1'b0, 3'd0, 8'hFF, 3'd1, 4'd4, 8'h0D, 1'b1, 1'b0}, // R2 broadcast, 4 agents
        {2'd0, 1'b0, 3'd0, 8'h05, 3'd2, 4'd8, 8'h20, 1'b0, 1'b0}, // R3 unicast
        {2'd0, 1'b0, 3'd0, 8'h02, 3'd2, 4'd8, 8'h00, 1'b1, 1'b0}, // R3 unicast to self
        {2'd0, 1'b0, 3'd0, 8'h06, 3'd0, 4'd4, 8'h00, 1'b0, 1'b0}, // R3 out of range
        {2'd0, 1'b0, 3'd1, 8'h03, 3'd0, 4'd8, 8'h00, 1'b0, 1'b1}, // R8 physical lowest
        {2'd0, 1'b1, 3'd1, 8'hFF, 3'd0, 4'd8, 8'h00, 1'b0, 1'b1}, // R8 logical lowest
        {2'd1, 1'b0, 3'd0, 8'h00, 3'd4, 4'd8, 8'h00, 1'b1, 1'b0}, // R5 self only
        {2'd2, 1'b0, 3'd0, 8'h00, 3'd4, 4'd5, 8'h0F, 1'b1, 1'b0}, // R6 all incl self
        {2'd3, 1'b0, 3'd0, 8'h00, 3'd0, 4'd8, 8'hFE, 1'b0, 1'b0}, // R7 all excl self
        {2'd3, 1'b0, 3'd1, 8'h00, 3'd7, 4'd8, 8'h7F, 1'b0, 1'b0}, // R7 R8 lowest allowed
        {2'd3, 1'b0, 3'd0, 8'h00, 3'd5, 4'd3, 8'h07, 1'b0, 1'b0}  // R7 sender beyond count
    };

    function automatic string vec_tag(input int k);
        case (k)
            0:       return "R1/R4";
            1, 2:    return "R1";
            3, 4:    return "R2";
            5, 6, 7: return "R3";
            8, 9:    return "R8";
            10:      return "R5";
            11:      return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [31:0] mk_cmd(input logic [1:0] sh, input logic lg,
                                           input logic [2:0] dlv, input logic [7:0] vec,
                                           input logic trig);
        return {12'b0, sh, 2'b0, trig, 2'b0, 1'b0, lg, dlv, vec};
    endfunction

    function automatic int sat_next(input int cur, input int add, input bit done);
        int v;
        v = cur + add;
        if (done && v > 0) v = v - 1;
        if (v > 255) v = 255;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Drive one write (optionally with a completion) and return one negedge later.
    task automatic do_write(input logic [31:0] w, input logic [7:0] d,
                            input logic [2:0] own, input logic [3:0] cnt, input bit done);
        @(negedge clk);
        cmd_wr     = 1'b1;
        cmd_wdata  = w;
        dest_field = d;
        own_id     = own;
        agent_cnt  = cnt;
        ipi_done   = done;
        @(negedge clk);
        cmd_wr   = 1'b0;
        ipi_done = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        ipi_done = 1'b1;
        @(negedge clk);
        ipi_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_pend = 0;
    endtask

    initial begin
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; dest_field = '0;
        own_id = '0; agent_cnt = 4'd8; ipi_done = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(tgt_mask == 0 && !local_req && !cmd_err, "R12", "dispatch outputs",
            {tgt_mask, local_req, cmd_err}, 0);
        chk(pending == 0, "R12", "pending", pending, 0);
        chk(cmd_rdata == 0, "R12", "cmd_rdata", cmd_rdata, 0);
        rst_n = 1'b1;

        // Table walk: every shorthand, mode and boundary.
        for (int k = 0; k < NVEC; k++) begin
            logic [1:0]  sh;   logic lg;   logic [2:0] dlv;  logic [7:0] dst;
            logic [2:0]  own;  logic [3:0] cnt;
            logic [7:0]  emask; logic eloc; logic eerr;
            logic [7:0]  vec;  logic trig;
            {sh, lg, dlv, dst, own, cnt, emask, eloc, eerr} = VEC[k];
            vec  = 8'h30 + 8'(k);
            trig = k[0];
            do_write(mk_cmd(sh, lg, dlv, vec, trig), dst, own, cnt, 1'b0);
            exp_pend = sat_next(exp_pend, $countones(emask), 1'b0);
            chk(tgt_mask == emask, vec_tag(k), "tgt_mask", tgt_mask, emask);
            chk(local_req == eloc, vec_tag(k), "local_req", local_req, eloc);
            chk(cmd_err == eerr, vec_tag(k), "cmd_err", cmd_err, eerr);
            chk(int'(pending) == exp_pend, "R10", "pending after table write", pending, exp_pend);
            if (eloc) begin
                // R4: payload of the self-delivery
                chk(local_vector == vec && local_mode == dlv && local_trig == trig, "R4",
                    "local payload", {local_vector, local_mode, local_trig}, {vec, dlv, trig});
            end
            @(negedge clk);
            // R9: results last exactly one cycle
            chk(tgt_mask == 0 && !local_req && !cmd_err, "R9", "outputs cleared",
                {tgt_mask, local_req, cmd_err}, 0);
        end

        // R11: software value of the status bit is ignored.
        do_reset();
        begin
            logic [31:0] w;
            w = mk_cmd(2'd0, 1'b0, 3'd1, 8'h77, 1'b1) | 32'h0000_1000;
            do_write(w, 8'h03, 3'd0, 4'd8, 1'b0);
            chk(cmd_rdata == (w & ~32'h0000_1000), "R11", "readback, nothing pending",
                cmd_rdata, w & ~32'h0000_1000);
            w = mk_cmd(2'd3, 1'b0, 3'd0, 8'h21, 1'b0);
            do_write(w, 8'h00, 3'd0, 4'd4, 1'b0);
            exp_pend = sat_next(exp_pend, 3, 1'b0);
            chk(cmd_rdata == (w | 32'h0000_1000), "R11", "readback, pending set",
                cmd_rdata, w | 32'h0000_1000);
            // R10: completion together with a write
            do_write(w, 8'h00, 3'd0, 4'd4, 1'b1);
            exp_pend = sat_next(exp_pend, 3, 1'b1);
            chk(int'(pending) == exp_pend, "R10", "write plus completion", pending, exp_pend);
            for (int j = 0; j < 5; j++) begin
                pulse_done();
                exp_pend = sat_next(exp_pend, 0, 1'b1);
            end
            chk(int'(pending) == exp_pend, "R10", "drained", pending, exp_pend);
            chk(cmd_rdata[12] == 1'b0, "R11", "status cleared", cmd_rdata[12], 0);
            pulse_done();
            chk(pending == 0, "R10", "no underflow", pending, 0);
        end

        // R10: saturation at the top.
        for (int j = 0; j < 40; j++) begin
            do_write(mk_cmd(2'd3, 1'b0, 3'd0, 8'h10, 1'b0), 8'h00, 3'd0, 4'd8, 1'b0);
            exp_pend = sat_next(exp_pend, 7, 1'b0);
        end
        chk(int'(pending) == exp_pend && exp_pend == 255, "R10", "saturated", pending, exp_pend);
        do_write(mk_cmd(2'd3, 1'b0, 3'd0, 8'h10, 1'b0), 8'h00, 3'd0, 4'd8, 1'b1);
        exp_pend = sat_next(exp_pend, 7, 1'b1);
        chk(int'(pending) == exp_pend, "R10", "saturated with completion", pending, exp_pend);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule